// File: doc/BRIEF.md
# I2C Slave Address Recognition and Acknowledge Decision

This block decides, byte by byte, whether an I2C port pulls SDA low in the acknowledge slot. It works alongside a separate bit shifter and SCL timing engine. It receives the completed byte together with single-cycle strobes for byte completion, START and STOP. It also receives the operating mode, a programmable 7-bit own address, an acknowledge-enable flag and a general call enable.

In slave mode, the first byte after a START is compared against the own address and against the general call code. A match leaves the block in the addressed condition until the next STOP or START. The read/write bit of a matched own address selects receiver or transmitter. While not addressed, the block keeps following START and STOP, but it answers no byte and raises no interrupt request. Clearing the acknowledge-enable flag therefore releases the port from the bus. Setting the flag again restores address recognition for the next address byte, even if that byte has already started to arrive.

In master receiver mode, every data byte is answered from the acknowledge-enable flag. In slave transmitter mode, the final transmitted byte leads to a last-byte state. Clearing the interrupt in that state returns the block to the not-addressed condition.

Top module: `slv_addr_ack`

## Requirements
- R1: In slave mode, with ack_en=1, an address byte (the first byte after START) whose upper 7 bits equal own_addr, and which is not 0x00, produces one cycle later resp_vld=1, ack_low=1, own_hit=1 and irq_req=1. It also sets addressed=1. slv_tx takes the value of rx_byte bit 0 (1 = read, so the block transmits).
- R2: An address byte equal to 0x00 (general call) is acknowledged only when ack_en=1 and gc_en=1. In that case the block gives gc_hit=1, ack_low=1, resp_vld=1, irq_req=1 and addressed=1 with slv_tx=0. Otherwise the byte is handled as a mismatch.
- R3: An address byte that does not match, or any address byte while ack_en=0, produces resp_vld=0, ack_low=0 and irq_req=0, and leaves the block not addressed.
- R4: For mode=2'b01 (master receiver), each completed byte produces one cycle later resp_vld=1, irq_req=1 and ack_low equal to ack_en at byte completion (1 = ACK, 0 = NACK).
- R5: In slave mode, while addressed as receiver, each completed data byte produces resp_vld=1, irq_req=1 and ack_low equal to ack_en at byte completion.
- R6: In slave mode, while not addressed and not awaiting an address byte, completed bytes produce no response, no ACK and no interrupt request.
- R7: ack_en is sampled only at byte completion. A flag raised while the address byte is still arriving (ack_en=0 in earlier cycles) still lets that byte match.
- R8: A STOP clears addressed, slv_tx and last_st. A START does the same and also arms address comparison for the next byte. When strobes coincide, START takes precedence over STOP, and STOP over byte completion.
- R9: While addressed as transmitter, a completed byte gives irq_req=1 with resp_vld=0 and ack_low=0. If tx_last=1 at that byte, the block enters the last-byte state (last_st=1).
- R10: In the last-byte state, completed bytes are ignored and irq_clr moves the block to not addressed. If ack_en is set again there, the next START followed by the own address is recognized.
- R11: After reset all outputs are 0 and the block is not addressed.
- R12: For mode=2'b10 or 2'b11 (master transmitter), completed bytes produce no response and no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_addr | input | 7 | Programmable own slave address |
| gc_en | input | 1 | General call recognition enable |
| ack_en | input | 1 | Assert-acknowledge flag |
| mode | input | 2 | 00 slave, 01 master receiver, 10/11 master transmitter |
| start_pulse | input | 1 | START or repeated START detected |
| stop_pulse | input | 1 | STOP detected |
| byte_done | input | 1 | A byte has completed (received or transmitted) |
| rx_byte | input | 8 | Completed byte, address in bits 7:1, R/W in bit 0 |
| tx_last | input | 1 | The completed transmitted byte is the final one |
| irq_clr | input | 1 | Interrupt flag cleared by software |
| resp_vld | output | 1 | The block decides the acknowledge slot for this byte |
| ack_low | output | 1 | Pull SDA low in the acknowledge slot (ACK) |
| own_hit | output | 1 | Own address recognized |
| gc_hit | output | 1 | General call recognized |
| irq_req | output | 1 | Interrupt request pulse |
| addressed | output | 1 | Block is an addressed slave |
| slv_tx | output | 1 | Addressed as transmitter |
| last_st | output | 1 | Last-byte-transmitted state |

## Verification
The bench builds the block with its default parameters: a 7-bit address and a general call code of 0x00. These defaults give both compare paths their real I2C meaning. The own address changes at run time, so matching is tested against several addresses. The random bytes are biased toward the own address with either R/W value and toward 0x00, which keeps matches, general calls and near-miss mismatches frequent. Directed sequences cover the flag raised during the address byte, coinciding strobes and re-enabling recognition in the last-byte state.

// File: rtl/saa_pkg.sv
package saa_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_ADDRD = 2'd2,
        PH_LAST  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        MD_SLAVE = 2'd0,
        MD_MRX   = 2'd1,
        MD_MTX   = 2'd2,
        MD_RSVD  = 2'd3
    } mode_e;

    typedef struct packed {
        phase_e phase;
        logic   rd;
        logic   resp_vld;
        logic   ack_low;
        logic   own_hit;
        logic   gc_hit;
        logic   irq;
    } ctl_s;
endpackage

// File: rtl/saa_addr_cmp.sv
module saa_addr_cmp #(
    parameter int ADDR_W  = 7,
    parameter int GC_CODE = 0,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    output logic              own_match,
    output logic              gc_match,
    output logic              rw_bit
);
    localparam logic [BYTE_W-1:0] GC_VAL = BYTE_W'(GC_CODE);

    logic is_gc;

    always_comb begin
        is_gc     = (rx_byte == GC_VAL);
        gc_match  = ack_en && gc_en && is_gc;
        own_match = ack_en && !is_gc && (rx_byte[BYTE_W-1:1] == own_addr);
        rw_bit    = rx_byte[0];
    end
endmodule

// File: rtl/saa_ack_sel.sv
module saa_ack_sel
    import saa_pkg::*;
(
    input  phase_e phase,
    input  logic   rd,
    input  mode_e  mode,
    input  logic   ack_en,
    input  logic   own_match,
    input  logic   gc_match,
    input  logic   rw_bit,
    input  logic   tx_last,
    output phase_e nxt_phase,
    output logic   nxt_rd,
    output logic   resp,
    output logic   ack,
    output logic   own_o,
    output logic   gc_o,
    output logic   irq
);
    always_comb begin
        nxt_phase = phase;
        nxt_rd    = rd;
        resp      = 1'b0;
        ack       = 1'b0;
        own_o     = 1'b0;
        gc_o      = 1'b0;
        irq       = 1'b0;
        unique case (mode)
            MD_MRX: begin
                resp = 1'b1;
                ack  = ack_en;
                irq  = 1'b1;
            end
            MD_SLAVE: begin
                unique case (phase)
                    PH_ARMED: begin
                        if (own_match || gc_match) begin
                            resp      = 1'b1;
                            ack       = 1'b1;
                            irq       = 1'b1;
                            own_o     = own_match;
                            gc_o      = gc_match;
                            nxt_phase = PH_ADDRD;
                            nxt_rd    = own_match ? rw_bit : 1'b0;
                        end else begin
                            nxt_phase = PH_IDLE;
                            nxt_rd    = 1'b0;
                        end
                    end
                    PH_ADDRD: begin
                        irq = 1'b1;
                        if (!rd) begin
                            resp = 1'b1;
                            ack  = ack_en;
                        end else if (tx_last) begin
                            nxt_phase = PH_LAST;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/slv_addr_ack.sv
module slv_addr_ack
    import saa_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int GC_CODE = 0,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic [1:0]        mode,
    input  logic              start_pulse,
    input  logic              stop_pulse,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_last,
    input  logic              irq_clr,
    output logic              resp_vld,
    output logic              ack_low,
    output logic              own_hit,
    output logic              gc_hit,
    output logic              irq_req,
    output logic              addressed,
    output logic              slv_tx,
    output logic              last_st
);
    ctl_s   ctl_d, ctl_q;
    logic   own_match, gc_match, rw_bit;
    phase_e sel_phase;
    logic   sel_rd, sel_resp, sel_ack, sel_own, sel_gc, sel_irq;
    logic   armed;

    saa_addr_cmp #(
        .ADDR_W (ADDR_W),
        .GC_CODE(GC_CODE)
    ) u_cmp (
        .rx_byte  (rx_byte),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .ack_en   (ack_en),
        .own_match(own_match),
        .gc_match (gc_match),
        .rw_bit   (rw_bit)
    );

    saa_ack_sel u_sel (
        .phase    (ctl_q.phase),
        .rd       (ctl_q.rd),
        .mode     (mode_e'(mode)),
        .ack_en   (ack_en),
        .own_match(own_match),
        .gc_match (gc_match),
        .rw_bit   (rw_bit),
        .tx_last  (tx_last),
        .nxt_phase(sel_phase),
        .nxt_rd   (sel_rd),
        .resp     (sel_resp),
        .ack      (sel_ack),
        .own_o    (sel_own),
        .gc_o     (sel_gc),
        .irq      (sel_irq)
    );

    // Strobe priority: START, then STOP, then byte completion, then irq_clr.
    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.resp_vld = 1'b0;
        ctl_d.ack_low  = 1'b0;
        ctl_d.own_hit  = 1'b0;
        ctl_d.gc_hit   = 1'b0;
        ctl_d.irq      = 1'b0;
        if (start_pulse) begin
            ctl_d.phase = PH_ARMED;
            ctl_d.rd    = 1'b0;
        end else if (stop_pulse) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.rd    = 1'b0;
        end else if (byte_done) begin
            ctl_d.phase    = sel_phase;
            ctl_d.rd       = sel_rd;
            ctl_d.resp_vld = sel_resp;
            ctl_d.ack_low  = sel_ack;
            ctl_d.own_hit  = sel_own;
            ctl_d.gc_hit   = sel_gc;
            ctl_d.irq      = sel_irq;
        end else if (irq_clr && ctl_q.phase == PH_LAST) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.rd    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, default: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        resp_vld  = ctl_q.resp_vld;
        ack_low   = ctl_q.ack_low;
        own_hit   = ctl_q.own_hit;
        gc_hit    = ctl_q.gc_hit;
        irq_req   = ctl_q.irq;
        addressed = (ctl_q.phase == PH_ADDRD) || (ctl_q.phase == PH_LAST);
        slv_tx    = addressed && ctl_q.rd;
        last_st   = (ctl_q.phase == PH_LAST);
        armed     = (ctl_q.phase == PH_ARMED);
    end
endmodule

// File: rtl/slv_addr_ack_chk.sv
module slv_addr_ack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gc_en,
    input logic       ack_en,
    input logic [1:0] mode,
    input logic       start_pulse,
    input logic       stop_pulse,
    input logic       byte_done,
    input logic       irq_clr,
    input logic       resp_vld,
    input logic       ack_low,
    input logic       own_hit,
    input logic       gc_hit,
    input logic       irq_req,
    input logic       addressed,
    input logic       last_st,
    input logic       armed
);
    a_r1_own_hit_acks: assert property (@(posedge clk) disable iff (!rst_n)
        own_hit |-> (ack_low && resp_vld && irq_req && addressed));

    a_r2_gc_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !start_pulse && !stop_pulse |=> (!gc_hit || ($past(gc_en) && $past(ack_en))));

    a_r4_mrx_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && mode == 2'b01 && !start_pulse && !stop_pulse
        |=> resp_vld && irq_req && (ack_low == $past(ack_en)));

    a_r6_unaddressed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && mode == 2'b00 && !addressed && !armed
        |=> !resp_vld && !irq_req && !ack_low);

    a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !addressed && !last_st);

    a_r10_clear_leaves_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_st && irq_clr && !start_pulse && !stop_pulse && !byte_done |=> !addressed);

    a_r12_mtx_silent: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && mode[1] && !start_pulse && !stop_pulse |=> !resp_vld && !irq_req);
endmodule

bind slv_addr_ack slv_addr_ack_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gc_en      (gc_en),
    .ack_en     (ack_en),
    .mode       (mode),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .byte_done  (byte_done),
    .irq_clr    (irq_clr),
    .resp_vld   (resp_vld),
    .ack_low    (ack_low),
    .own_hit    (own_hit),
    .gc_hit     (gc_hit),
    .irq_req    (irq_req),
    .addressed  (addressed),
    .last_st    (last_st),
    .armed      (armed)
);

// File: tb/slv_addr_ack_tb_top.sv
module slv_addr_ack_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] own_addr = 7'h2A;
    logic       gc_en = 1'b0;
    logic       ack_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       start_pulse = 1'b0;
    logic       stop_pulse = 1'b0;
    logic       byte_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_last = 1'b0;
    logic       irq_clr = 1'b0;
    logic       resp_vld, ack_low, own_hit, gc_hit, irq_req, addressed, slv_tx, last_st;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model: 0 idle, 1 waiting for address, 2 addressed, 3 last byte sent
    int m_ph = 0;
    bit m_rd = 1'b0;
    bit e_resp, e_ack, e_own, e_gc, e_irq;
    string tag = "R11";

    always #4 clk = ~clk;

    slv_addr_ack dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en),
        .mode(mode), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .byte_done(byte_done), .rx_byte(rx_byte), .tx_last(tx_last), .irq_clr(irq_clr),
        .resp_vld(resp_vld), .ack_low(ack_low), .own_hit(own_hit), .gc_hit(gc_hit),
        .irq_req(irq_req), .addressed(addressed), .slv_tx(slv_tx), .last_st(last_st)
    );

    task automatic chk(string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Reference behaviour built from the requirements; called after the edge.
    task automatic model_edge();
        bit is_gc, own_m, gc_m;
        e_resp = 0; e_ack = 0; e_own = 0; e_gc = 0; e_irq = 0;
        tag = "R6";
        if (start_pulse) begin
            tag = "R8"; m_ph = 1; m_rd = 0;
        end else if (stop_pulse) begin
            tag = "R8"; m_ph = 0; m_rd = 0;
        end else if (byte_done) begin
            if (mode == 2'b01) begin
                tag = "R4"; e_resp = 1; e_irq = 1; e_ack = ack_en;
            end else if (mode != 2'b00) begin
                tag = "R12";
            end else if (m_ph == 1) begin
                is_gc = (rx_byte == 8'h00);
                gc_m  = is_gc && gc_en && ack_en;
                own_m = !is_gc && ack_en && (rx_byte[7:1] == own_addr);
                if (own_m) begin
                    tag = "R1"; e_resp = 1; e_ack = 1; e_irq = 1; e_own = 1;
                    m_ph = 2; m_rd = rx_byte[0];
                end else if (gc_m) begin
                    tag = "R2"; e_resp = 1; e_ack = 1; e_irq = 1; e_gc = 1;
                    m_ph = 2; m_rd = 0;
                end else begin
                    tag = is_gc ? "R2" : "R3"; m_ph = 0; m_rd = 0;
                end
            end else if (m_ph == 2 && !m_rd) begin
                tag = "R5"; e_resp = 1; e_irq = 1; e_ack = ack_en;
            end else if (m_ph == 2) begin
                tag = "R9"; e_irq = 1;
                if (tx_last) m_ph = 3;
            end else begin
                tag = (m_ph == 3) ? "R10" : "R6";
            end
        end else if (irq_clr && m_ph == 3) begin
            tag = "R10"; m_ph = 0; m_rd = 0;
        end
    endtask

    task automatic compare();
        chk("resp_vld", resp_vld, e_resp);
        chk("ack_low", ack_low, e_ack);
        chk("own_hit", own_hit, e_own);
        chk("gc_hit", gc_hit, e_gc);
        chk("irq_req", irq_req, e_irq);
        chk("addressed", addressed, (m_ph == 2 || m_ph == 3));
        chk("slv_tx", slv_tx, (m_ph == 2 || m_ph == 3) && m_rd);
        chk("last_st", last_st, m_ph == 3);
    endtask

    // Inputs are set at a falling edge; one rising edge later they are sampled,
    // and outputs are checked at the next falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        start_pulse = 0; stop_pulse = 0; byte_done = 0; irq_clr = 0; tx_last = 0;
    endtask

    task automatic ev_start(); start_pulse = 1; step(); endtask
    task automatic ev_stop();  stop_pulse = 1;  step(); endtask
    task automatic ev_byte(logic [7:0] b, logic last);
        rx_byte = b; tx_last = last; byte_done = 1; step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R11: reset state
        tag = "R11";
        e_resp = 0; e_ack = 0; e_own = 0; e_gc = 0; e_irq = 0;
        compare();
        rst_n = 1;
        @(negedge clk);

        // R1: own address write, then R5 data with ACK and NACK
        ack_en = 1;
        ev_start(); ev_byte({own_addr, 1'b0}, 0);
        ev_byte(8'h5C, 0);
        ack_en = 0; ev_byte(8'h11, 0);
        ack_en = 1; ev_stop();

        // R2: general call refused while disabled, then accepted
        gc_en = 0; ev_start(); ev_byte(8'h00, 0);
        ev_byte(8'h33, 0);
        gc_en = 1; ev_start(); ev_byte(8'h00, 0);
        ev_stop();

        // R3: mismatch
        ev_start(); ev_byte({own_addr ^ 7'h01, 1'b0}, 0); ev_byte(8'hA5, 0);

        // R7: flag raised while address byte is arriving
        ack_en = 0; ev_start();
        step(); step();
        ack_en = 1; ev_byte({own_addr, 1'b0}, 0);

        // R8: repeated START ends addressing; START beats byte completion
        ev_start();
        start_pulse = 1; rx_byte = {own_addr, 1'b0}; byte_done = 1; step();
        ev_byte({own_addr, 1'b1}, 0);

        // R9/R10: transmitter, last byte, flag re-enabled in last state
        ev_byte(8'h00, 0);
        ack_en = 0; ev_byte(8'h00, 1);
        ev_byte({own_addr, 1'b0}, 0);
        ack_en = 1; irq_clr = 1; step();
        ev_byte({own_addr, 1'b0}, 0);
        ev_start(); ev_byte({own_addr, 1'b0}, 0);
        ev_stop();

        // R4 / R12: master modes
        mode = 2'b01; ev_byte(8'h77, 0); ack_en = 0; ev_byte(8'h78, 0);
        mode = 2'b10; ev_byte(8'h79, 0);
        mode = 2'b11; ev_byte(8'h7A, 0);
        mode = 2'b00; ack_en = 1;

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (i % 500 == 0) own_addr = 7'($urandom_range(1, 127));
            ack_en = ($urandom_range(0, 3) != 0);
            gc_en  = $urandom_range(0, 1);
            case ($urandom_range(0, 9))
                0: mode = 2'b01;
                1: mode = 2'($urandom_range(2, 3));
                default: mode = 2'b00;
            endcase
            if (r < 12) begin
                start_pulse = 1;
            end else if (r < 17) begin
                stop_pulse = 1;
            end else if (r < 80) begin
                case ($urandom_range(0, 4))
                    0, 1: rx_byte = {own_addr, 1'($urandom_range(0, 1))};
                    2: rx_byte = 8'h00;
                    default: rx_byte = 8'($urandom_range(0, 255));
                endcase
                tx_last = ($urandom_range(0, 2) == 0);
                byte_done = 1;
            end else if (r < 90) begin
                irq_clr = 1;
            end
            step();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule